// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one disk DMA transfer that a channel carries out as a series of descriptor chunks. A start command samples the drive kind, the command code and the base address, and loads the total byte count. For a disk the total is the sector count times 512. For an optical drive the total is the packet size. The start also clears the progress index and pulses a kick toward the DMA channel.

Every time the channel reports a chunk, the sequencer passes it down a fixed decision ladder and takes exactly one action:
- abort with an error,
- stall because no transfer is running,
- complete the whole transfer,
- close only the current descriptor,
- copy a non-block optical result directly,
- or issue the chunk to storage as a read, a write or a trim at the computed byte offset.

All outputs are registered. Each decision appears at the ports one clock after the chunk report is sampled. The status byte keeps its value until the next start. The interrupt is a single-cycle pulse.

Top module: `ide_dma_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every output to zero, including status_o = 8'h00, and leaves no transfer running.
- R2: A start_i sampled at an edge pulses kick_o for the following cycle and sets status_o to 8'h80. It loads the remaining size as sector_cnt_i*512 when optical_i=0 or as pkt_size_i when optical_i=1, and clears the progress index. optical_i, cmd_i, sector_pos_i and blk_addr_i are sampled only at that start.
- R3: A chunk report (chunk_valid_i) that arrives while no transfer is running pulses stall_o and nothing else: no request, no descriptor end, no interrupt, and no status change.
- R4: A chunk report with chunk_err_i=1 during a running transfer sets status_o to 8'h41, pulses irq_o and desc_end_o, and ends the transfer. An error takes priority over every other outcome.
- R5: A chunk report that arrives when the remaining size is zero or negative sets status_o to 8'h50, pulses irq_o and desc_end_o, and ends the transfer. This applies to both drive kinds.
- R6: A chunk report of length zero, with no error and a positive remaining size, pulses only desc_end_o. The transfer keeps running, and the index and the remaining size are unchanged.
- R7: An issued disk chunk has req_off_o = sector_pos*512 + index. After the chunk, the index grows by the chunk length and the remaining size shrinks by it, and may go negative.
- R8: An issued optical chunk has req_off_o = blk_addr*2048 + index and always uses req_op_o = 0 (read).
- R9: For a disk, the latched cmd_i selects req_op_o: 0 gives read (0), 1 gives write (1), 2 gives trim (2), and 3 is treated as read (0).
- R10: An optical transfer whose latched blk_addr_i is all ones is non-block. Its first non-empty chunk issues req_op_o = 3 (copy) with req_off_o = 0 and req_len_o = min(remaining, chunk length). It sets status_o to 8'h50, pulses irq_o and desc_end_o, and ends the transfer.
- R11: irq_o never stays high for two consecutive cycles. status_o changes only at a start or at a transfer-ending chunk.
- R12: When start_i and chunk_valid_i are high in the same cycle, the start wins and the chunk is dropped. This also restarts a transfer that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start command pulse |
| cmd_i | input | 2 | Disk command code: 0 read, 1 write, 2 trim |
| optical_i | input | 1 | Drive kind: 1 optical, 0 disk |
| sector_cnt_i | input | SECW | Disk sector count |
| pkt_size_i | input | PKTW | Optical packet transfer size in bytes |
| sector_pos_i | input | LBAW | Disk starting sector |
| blk_addr_i | input | LBAW | Optical block address, all ones for non-block |
| chunk_valid_i | input | 1 | Channel reports a chunk |
| chunk_len_i | input | LENW | Length of the reported chunk in bytes |
| chunk_err_i | input | 1 | Reported chunk carries an error |
| kick_o | output | 1 | Pulse asking the DMA channel to begin |
| req_valid_o | output | 1 | Chunk request valid (one cycle) |
| req_op_o | output | 2 | Request kind: 0 read, 1 write, 2 trim, 3 copy |
| req_off_o | output | OFFW | Request byte offset |
| req_len_o | output | LENW | Request length in bytes |
| desc_end_o | output | 1 | Current descriptor finished (pulse) |
| stall_o | output | 1 | Chunk not processed, waiting for restart (pulse) |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest situation to reach is a transfer whose remaining size has already been driven below zero by an overlong chunk. Only the next chunk report shows that the block ends the transfer instead of issuing more data. The stimulus reaches it on purpose: it sizes chunks that do not divide the total, on both drive kinds, and follows with one more report. Two more situations need deliberate timing. The first is the non-block optical copy, where the packet size is made smaller and then larger than the chunk so that both sides of the minimum are selected. The second is a start that arrives in the same cycle as a chunk report in the middle of a transfer.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

  // Controller states.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_WAIT_CHUNK,
    ST_PAUSED,
    ST_DONE
  } seq_state_e;

  // Single decision taken in a cycle.
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LOAD,
    ACT_PAUSE,
    ACT_ERROR,
    ACT_FINISH,
    ACT_DESC_END,
    ACT_COPY,
    ACT_ISSUE
  } seq_act_e;

  localparam logic [7:0] STAT_BUSY  = 8'h80;
  localparam logic [7:0] STAT_READY = 8'h40;
  localparam logic [7:0] STAT_SEEK  = 8'h10;
  localparam logic [7:0] STAT_ERR   = 8'h01;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_TRIM  = 2'd2;
  localparam logic [1:0] OP_COPY  = 2'd3;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Total byte count of a transfer.
  function automatic logic [63:0] total_bytes(input logic optical,
                                              input logic [63:0] sec_cnt,
                                              input logic [63:0] pkt);
    return optical ? pkt : (sec_cnt << 9);
  endfunction

  // Byte offset of the next chunk.
  function automatic logic [63:0] chunk_offset(input logic optical,
                                               input logic [63:0] base,
                                               input logic [63:0] idx);
    return optical ? ((base << 11) + idx) : ((base << 9) + idx);
  endfunction

  // Length of a direct copy: the smaller of remaining and chunk length.
  function automatic logic [63:0] clip_len(input logic [63:0] rem,
                                           input logic [63:0] len);
    return (rem < len) ? rem : len;
  endfunction

  // Request kind of an issued chunk.
  function automatic logic [1:0] map_op(input logic optical, input logic [1:0] cmd);
    if (optical) return OP_READ;
    case (cmd)
      2'd1:    return OP_WRITE;
      2'd2:    return OP_TRIM;
      default: return OP_READ;
    endcase
  endfunction

endpackage

// File: rtl/ide_seq_ctx.sv
// Holds the per-transfer context sampled at a start.
module ide_seq_ctx
  import ide_seq_pkg::*;
#(
  parameter int LBAW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_act_e        act,
  input  logic            optical_i,
  input  logic [1:0]      cmd_i,
  input  logic [LBAW-1:0] sector_pos_i,
  input  logic [LBAW-1:0] blk_addr_i,
  output logic            ctx_opt,
  output logic [1:0]      ctx_cmd,
  output logic [LBAW-1:0] ctx_base,
  output logic            ctx_nonblk
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_opt    <= 1'b0;
      ctx_cmd    <= 2'd0;
      ctx_base   <= '0;
      ctx_nonblk <= 1'b0;
    end else if (act == ACT_LOAD) begin
      ctx_opt    <= optical_i;
      ctx_cmd    <= cmd_i;
      ctx_base   <= optical_i ? blk_addr_i : sector_pos_i;
      // all-ones block address marks a non-block optical transfer
      ctx_nonblk <= optical_i && (&blk_addr_i);
    end
  end

endmodule

// File: rtl/ide_seq_track.sv
// Remaining-size and progress-index bookkeeping of one transfer.
module ide_seq_track
  import ide_seq_pkg::*;
#(
  parameter int SECW = 16,
  parameter int PKTW = 20,
  parameter int LENW = 16,
  parameter int REMW = 27
) (
  input  logic                   clk,
  input  logic                   rst,
  input  seq_act_e               act,
  input  logic                   optical_i,
  input  logic [SECW-1:0]        sector_cnt_i,
  input  logic [PKTW-1:0]        pkt_size_i,
  input  logic [LENW-1:0]        chunk_len_i,
  input  logic [LENW-1:0]        clip_len_i,
  output logic signed [REMW-1:0] rem_q,
  output logic [REMW-1:0]        idx_q,
  output logic                   rem_le0
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      idx_q <= '0;
    end else begin
      case (act)
        ACT_LOAD: begin
          rem_q <= $signed(REMW'(total_bytes(optical_i, 64'(sector_cnt_i), 64'(pkt_size_i))));
          idx_q <= '0;
        end
        ACT_ISSUE: begin
          rem_q <= rem_q - $signed(REMW'(chunk_len_i));
          idx_q <= idx_q + REMW'(chunk_len_i);
        end
        ACT_COPY: begin
          idx_q <= idx_q + REMW'(clip_len_i);
        end
        default: ;
      endcase
    end
  end

  // zero or negative remaining size
  assign rem_le0 = rem_q[REMW-1] || (rem_q == '0);

endmodule

// File: rtl/ide_seq_decide.sv
// Completion ladder: picks exactly one action per cycle.
module ide_seq_decide
  import ide_seq_pkg::*;
(
  input  logic     start_i,
  input  logic     chunk_valid_i,
  input  logic     chunk_err_i,
  input  logic     active,
  input  logic     rem_le0,
  input  logic     len_zero,
  input  logic     nonblk,
  output seq_act_e act
);

  always_comb begin
    act = ACT_NONE;
    if (start_i) begin
      act = ACT_LOAD;                 // start beats a coincident chunk
    end else if (chunk_valid_i) begin
      if (!active)          act = ACT_PAUSE;
      else if (chunk_err_i) act = ACT_ERROR;
      else if (rem_le0)     act = ACT_FINISH;
      else if (len_zero)    act = ACT_DESC_END;
      else if (nonblk)      act = ACT_COPY;
      else                  act = ACT_ISSUE;
    end
  end

endmodule

// File: rtl/ide_seq_emit.sv
// Registered outputs: request, pulses and the status byte.
module ide_seq_emit
  import ide_seq_pkg::*;
#(
  parameter int OFFW = 36,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_act_e        act,
  input  logic [1:0]      op_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [LENW-1:0] len_i,
  input  logic [LENW-1:0] clip_i,
  output logic            kick_o,
  output logic            req_valid_o,
  output logic [1:0]      req_op_o,
  output logic [OFFW-1:0] req_off_o,
  output logic [LENW-1:0] req_len_o,
  output logic            desc_end_o,
  output logic            stall_o,
  output logic [7:0]      status_o,
  output logic            irq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_o      <= 1'b0;
      req_valid_o <= 1'b0;
      req_op_o    <= 2'd0;
      req_off_o   <= '0;
      req_len_o   <= '0;
      desc_end_o  <= 1'b0;
      stall_o     <= 1'b0;
      status_o    <= 8'h00;
      irq_o       <= 1'b0;
    end else begin
      kick_o      <= (act == ACT_LOAD);
      req_valid_o <= (act == ACT_ISSUE) || (act == ACT_COPY);
      stall_o     <= (act == ACT_PAUSE);
      desc_end_o  <= (act == ACT_ERROR) || (act == ACT_FINISH) ||
                     (act == ACT_DESC_END) || (act == ACT_COPY);
      irq_o       <= (act == ACT_ERROR) || (act == ACT_FINISH) || (act == ACT_COPY);

      case (act)
        ACT_ISSUE: begin
          req_op_o  <= op_i;
          req_off_o <= off_i;
          req_len_o <= len_i;
        end
        ACT_COPY: begin
          req_op_o  <= OP_COPY;
          req_off_o <= '0;
          req_len_o <= clip_i;
        end
        default: begin
          req_op_o  <= 2'd0;
          req_off_o <= '0;
          req_len_o <= '0;
        end
      endcase

      case (act)
        ACT_LOAD:             status_o <= STAT_BUSY;
        ACT_ERROR:            status_o <= STAT_READY | STAT_ERR;
        ACT_FINISH, ACT_COPY: status_o <= STAT_READY | STAT_SEEK;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ide_dma_seq.sv
// IDE DMA transfer sequencer top.
module ide_dma_seq
  import ide_seq_pkg::*;
#(
  parameter int SECW = 16,
  parameter int PKTW = 20,
  parameter int LBAW = 24,
  parameter int LENW = 16,
  localparam int SZW  = max2(SECW + 9, PKTW),
  localparam int REMW = max2(SZW, LENW) + 2,
  localparam int OFFW = max2(LBAW + 11, REMW) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [1:0]      cmd_i,
  input  logic            optical_i,
  input  logic [SECW-1:0] sector_cnt_i,
  input  logic [PKTW-1:0] pkt_size_i,
  input  logic [LBAW-1:0] sector_pos_i,
  input  logic [LBAW-1:0] blk_addr_i,
  input  logic            chunk_valid_i,
  input  logic [LENW-1:0] chunk_len_i,
  input  logic            chunk_err_i,
  output logic            kick_o,
  output logic            req_valid_o,
  output logic [1:0]      req_op_o,
  output logic [OFFW-1:0] req_off_o,
  output logic [LENW-1:0] req_len_o,
  output logic            desc_end_o,
  output logic            stall_o,
  output logic [7:0]      status_o,
  output logic            irq_o
);

  seq_state_e             state_q;
  seq_act_e               act;
  logic                   active;
  logic                   ctx_opt;
  logic [1:0]             ctx_cmd;
  logic [LBAW-1:0]        ctx_base;
  logic                   ctx_nonblk;
  logic signed [REMW-1:0] rem_q;
  logic [REMW-1:0]        idx_q;
  logic                   rem_le0;
  logic [OFFW-1:0]        off_w;
  logic [LENW-1:0]        clip_w;
  logic [1:0]             op_w;

  // Named internal events for the checker.
  logic evt_load;
  logic evt_end;
  logic evt_issue;

  assign active    = (state_q == ST_ACTIVE) || (state_q == ST_WAIT_CHUNK);
  assign evt_load  = (act == ACT_LOAD);
  assign evt_end   = (act == ACT_ERROR) || (act == ACT_FINISH) || (act == ACT_COPY);
  assign evt_issue = (act == ACT_ISSUE);

  ide_seq_ctx #(.LBAW(LBAW)) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .optical_i    (optical_i),
    .cmd_i        (cmd_i),
    .sector_pos_i (sector_pos_i),
    .blk_addr_i   (blk_addr_i),
    .ctx_opt      (ctx_opt),
    .ctx_cmd      (ctx_cmd),
    .ctx_base     (ctx_base),
    .ctx_nonblk   (ctx_nonblk)
  );

  ide_seq_track #(.SECW(SECW), .PKTW(PKTW), .LENW(LENW), .REMW(REMW)) u_track (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .optical_i    (optical_i),
    .sector_cnt_i (sector_cnt_i),
    .pkt_size_i   (pkt_size_i),
    .chunk_len_i  (chunk_len_i),
    .clip_len_i   (clip_w),
    .rem_q        (rem_q),
    .idx_q        (idx_q),
    .rem_le0      (rem_le0)
  );

  ide_seq_decide u_decide (
    .start_i       (start_i),
    .chunk_valid_i (chunk_valid_i),
    .chunk_err_i   (chunk_err_i),
    .active        (active),
    .rem_le0       (rem_le0),
    .len_zero      (chunk_len_i == '0),
    .nonblk        (ctx_nonblk),
    .act           (act)
  );

  // Chunk arithmetic held in package functions.
  assign off_w  = OFFW'(chunk_offset(ctx_opt, 64'(ctx_base), 64'(idx_q)));
  assign clip_w = LENW'(clip_len(64'(rem_q), 64'(chunk_len_i)));
  assign op_w   = map_op(ctx_opt, ctx_cmd);

  ide_seq_emit #(.OFFW(OFFW), .LENW(LENW)) u_emit (
    .clk         (clk),
    .rst         (rst),
    .act         (act),
    .op_i        (op_w),
    .off_i       (off_w),
    .len_i       (chunk_len_i),
    .clip_i      (clip_w),
    .kick_o      (kick_o),
    .req_valid_o (req_valid_o),
    .req_op_o    (req_op_o),
    .req_off_o   (req_off_o),
    .req_len_o   (req_len_o),
    .desc_end_o  (desc_end_o),
    .stall_o     (stall_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

  // Controller state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (act)
        ACT_LOAD:                        state_q <= ST_ACTIVE;
        ACT_PAUSE:                       state_q <= ST_PAUSED;
        ACT_ERROR, ACT_FINISH, ACT_COPY: state_q <= ST_DONE;
        ACT_DESC_END, ACT_ISSUE:         state_q <= ST_WAIT_CHUNK;
        default: if (state_q == ST_ACTIVE) state_q <= ST_WAIT_CHUNK;
      endcase
    end
  end

endmodule

// File: rtl/ide_seq_chk.sv
// Property checker attached to the sequencer top.
module ide_seq_chk #(
  parameter int LENW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            chunk_valid_i,
  input logic            kick_o,
  input logic            req_valid_o,
  input logic [LENW-1:0] req_len_o,
  input logic            desc_end_o,
  input logic            stall_o,
  input logic [7:0]      status_o,
  input logic            irq_o,
  input logic            evt_load,
  input logic            evt_end,
  input logic            evt_issue
);

  // R2: a start is followed by a kick
  a_r2_kick_after_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> kick_o);

  // R2: an internal load event always produces busy status next cycle
  a_r2_busy_after_load: assert property (@(posedge clk) disable iff (rst)
    evt_load |=> (status_o == 8'h80));

  // R3: a stall comes alone
  a_r3_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (!req_valid_o && !irq_o && !desc_end_o));

  // R4 / R5: every interrupt closes the descriptor
  a_r4_irq_ends_desc: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> desc_end_o);

  // R7: an issued chunk is never empty
  a_r7_issue_nonempty: assert property (@(posedge clk) disable iff (rst)
    evt_issue |=> (req_valid_o && (req_len_o != '0)));

  // R11: interrupt is a single-cycle pulse
  a_r11_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R11: status holds outside a start or an ending chunk
  a_r11_status_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !evt_end) |=> $stable(status_o));

  // R12: a start beats a coincident chunk
  a_r12_start_wins: assert property (@(posedge clk) disable iff (rst)
    (start_i && chunk_valid_i) |=> (kick_o && !req_valid_o && !stall_o));

endmodule

bind ide_dma_seq ide_seq_chk #(.LENW(LENW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .chunk_valid_i (chunk_valid_i),
  .kick_o        (kick_o),
  .req_valid_o   (req_valid_o),
  .req_len_o     (req_len_o),
  .desc_end_o    (desc_end_o),
  .stall_o       (stall_o),
  .status_o      (status_o),
  .irq_o         (irq_o),
  .evt_load      (evt_load),
  .evt_end       (evt_end),
  .evt_issue     (evt_issue)
);

// File: tb/test_ide_dma_seq.sv
`timescale 1ns/1ps
module test_ide_dma_seq;

  localparam int SECW = 16;
  localparam int PKTW = 20;
  localparam int LBAW = 24;
  localparam int LENW = 16;
  localparam int OFFW = 36;

  logic            clk = 1'b0;
  logic            rst;
  logic            start_i;
  logic [1:0]      cmd_i;
  logic            optical_i;
  logic [SECW-1:0] sector_cnt_i;
  logic [PKTW-1:0] pkt_size_i;
  logic [LBAW-1:0] sector_pos_i;
  logic [LBAW-1:0] blk_addr_i;
  logic            chunk_valid_i;
  logic [LENW-1:0] chunk_len_i;
  logic            chunk_err_i;
  logic            kick_o;
  logic            req_valid_o;
  logic [1:0]      req_op_o;
  logic [OFFW-1:0] req_off_o;
  logic [LENW-1:0] req_len_o;
  logic            desc_end_o;
  logic            stall_o;
  logic [7:0]      status_o;
  logic            irq_o;

  always #2 clk = ~clk;  // 250 MHz

  ide_dma_seq i_ide_dma_seq (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Behavioural reference model state.
  bit     m_run;
  bit     m_opt;
  bit     m_nonblk;
  int     m_cmd;
  longint m_base, m_rem, m_idx;
  // Expected outputs.
  bit     e_kick, e_rv, e_de, e_stall, e_irq;
  int     e_op;
  longint e_off, e_len;
  int     e_status;

  task automatic model();
    e_kick = 0; e_rv = 0; e_de = 0; e_stall = 0; e_irq = 0;
    e_op = 0; e_off = 0; e_len = 0;
    if (rst) begin
      e_status = 0; m_run = 0; m_rem = 0; m_idx = 0;
    end else if (start_i) begin
      m_opt    = optical_i;
      m_cmd    = int'(cmd_i);
      m_base   = optical_i ? longint'(blk_addr_i) : longint'(sector_pos_i);
      m_nonblk = optical_i && (blk_addr_i == {LBAW{1'b1}});
      m_rem    = optical_i ? longint'(pkt_size_i) : longint'(sector_cnt_i) * 512;
      m_idx    = 0;
      m_run    = 1;
      e_kick   = 1;
      e_status = 'h80;
    end else if (chunk_valid_i) begin
      if (!m_run) begin
        e_stall = 1;
      end else if (chunk_err_i) begin
        e_status = 'h41; e_irq = 1; e_de = 1; m_run = 0;
      end else if (m_rem <= 0) begin
        e_status = 'h50; e_irq = 1; e_de = 1; m_run = 0;
      end else if (chunk_len_i == 0) begin
        e_de = 1;
      end else if (m_nonblk) begin
        e_rv = 1; e_op = 3; e_off = 0;
        e_len = (m_rem < longint'(chunk_len_i)) ? m_rem : longint'(chunk_len_i);
        e_status = 'h50; e_irq = 1; e_de = 1; m_run = 0;
      end else begin
        e_rv = 1;
        if (m_opt) e_op = 0;
        else if (m_cmd == 1) e_op = 1;
        else if (m_cmd == 2) e_op = 2;
        else e_op = 0;
        e_off = m_base * (m_opt ? 2048 : 512) + m_idx;
        e_len = longint'(chunk_len_i);
        m_rem = m_rem - longint'(chunk_len_i);
        m_idx = m_idx + longint'(chunk_len_i);
      end
    end
  endtask

  task automatic compare(input string tag);
    bit ok;
    ok = (kick_o == e_kick) && (req_valid_o == e_rv) && (int'(req_op_o) == e_op) &&
         (longint'(req_off_o) == e_off) && (longint'(req_len_o) == e_len) &&
         (desc_end_o == e_de) && (stall_o == e_stall) && (int'(status_o) == e_status) &&
         (irq_o == e_irq);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual kick=%0b rv=%0b op=%0d off=%0d len=%0d de=%0b stall=%0b st=%h irq=%0b expected kick=%0b rv=%0b op=%0d off=%0d len=%0d de=%0b stall=%0b st=%h irq=%0b",
               tag, kick_o, req_valid_o, req_op_o, req_off_o, req_len_o, desc_end_o, stall_o,
               status_o, irq_o, e_kick, e_rv, e_op, e_off, e_len, e_de, e_stall, e_status[7:0], e_irq);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag);
  endtask

  task automatic do_start(input bit opt, input int cmd, input int scnt, input int pkt,
                          input int spos, input int blk, input string tag);
    start_i = 1; optical_i = opt; cmd_i = 2'(cmd);
    sector_cnt_i = SECW'(scnt); pkt_size_i = PKTW'(pkt);
    sector_pos_i = LBAW'(spos); blk_addr_i = LBAW'(blk);
    step(tag);
    start_i = 0;
  endtask

  task automatic do_chunk(input int len, input bit err, input string tag);
    chunk_valid_i = 1; chunk_len_i = LENW'(len); chunk_err_i = err;
    step(tag);
    chunk_valid_i = 0; chunk_err_i = 0; chunk_len_i = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst = 1; start_i = 0; cmd_i = 0; optical_i = 0; sector_cnt_i = 0; pkt_size_i = 0;
    sector_pos_i = 0; blk_addr_i = 0; chunk_valid_i = 0; chunk_len_i = 0; chunk_err_i = 0;
    m_run = 0; m_opt = 0; m_nonblk = 0; m_cmd = 0; m_base = 0; m_rem = 0; m_idx = 0;
    e_status = 0;

    // R1: reset state
    idle("R1 reset");
    idle("R1 reset");
    rst = 0;
    idle("R1 after reset");
    // R3: chunk with no transfer running
    do_chunk(512, 0, "R3 stall when idle");

    // R2 R7 R9: disk read, two sectors at sector 100
    do_start(0, 0, 2, 0, 100, 0, "R2 start disk read");
    sector_pos_i = 24'd999;  // must be ignored after the start (R2)
    idle("R2 kick pulse over");
    do_chunk(512, 0, "R7 disk read chunk 1");
    do_chunk(0, 0, "R6 zero-length chunk");
    do_chunk(512, 0, "R7 disk read chunk 2 after empty");
    do_chunk(256, 0, "R5 finish at zero remaining");
    idle("R11 status holds");
    idle("R11 status holds");
    do_chunk(64, 0, "R3 stall after done");

    // R9 R7: disk write with overshoot to negative remaining
    do_start(0, 1, 1, 0, 7, 0, "R2 start disk write");
    do_chunk(300, 0, "R9 write chunk");
    do_chunk(300, 0, "R7 overshoot chunk");
    do_chunk(5, 0, "R5 finish on negative remaining");

    // R9: trim then error
    do_start(0, 2, 4, 0, 3, 0, "R2 start trim");
    do_chunk(1024, 0, "R9 trim chunk");
    do_chunk(1024, 1, "R4 error mid transfer");
    idle("R11 status after error");

    // R9: command 3 behaves as read; R4 error beats finish
    do_start(0, 3, 1, 0, 1, 0, "R2 start cmd3");
    do_chunk(512, 0, "R9 cmd3 issues read");
    do_chunk(8, 1, "R4 error beats finish");

    // R8: optical block transfer
    do_start(1, 1, 0, 5000, 0, 7, "R2 start optical");
    do_chunk(2048, 0, "R8 optical chunk 1");
    do_chunk(2048, 0, "R8 optical chunk 2");
    do_chunk(2048, 0, "R8 optical chunk 3");
    do_chunk(2048, 0, "R5 optical finish");

    // R10: non-block copy, both sides of the minimum
    do_start(1, 0, 0, 100, 0, 24'hFFFFFF, "R2 start nonblock small");
    do_chunk(0, 0, "R6 empty chunk before copy");
    do_chunk(512, 0, "R10 copy clipped to remaining");
    do_start(1, 0, 0, 1000, 0, 24'hFFFFFF, "R2 start nonblock large");
    do_chunk(200, 0, "R10 copy clipped to chunk");
    do_chunk(200, 0, "R3 stall after copy");

    // R12: start and chunk coincide mid transfer
    do_start(0, 0, 8, 0, 50, 0, "R2 start for restart");
    do_chunk(1024, 0, "R7 chunk before restart");
    chunk_valid_i = 1; chunk_len_i = 16'd512;
    do_start(0, 1, 1, 0, 60, 0, "R12 start wins over chunk");
    chunk_valid_i = 0; chunk_len_i = 0;
    do_chunk(512, 0, "R12 index cleared by restart");
    do_chunk(4, 0, "R5 finish after restart");

    // R1: reset in the middle of a transfer
    do_start(0, 0, 2, 0, 9, 0, "R2 start before reset");
    do_chunk(512, 0, "R7 chunk before reset");
    rst = 1;
    idle("R1 reset mid transfer");
    rst = 0;
    do_chunk(512, 0, "R1 no transfer after reset");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule